// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Bank

This block holds the per-channel trigger and interrupt state of a 64-channel DMA controller and exposes it through a small word-addressed register port. Each channel owns one bit in each state vector: a pending event, an event enable, an in-service (secondary) flag, an interrupt enable, an interrupt pending flag and a missed-event flag. Every state vector that software may change has dedicated set and clear addresses. Software never has to read, modify and write a vector.

Hardware request lines are edge-detected. A request latches an event only on an enabled channel. A request that lands on a channel which already has an event pending or in service is recorded as a missed event, and the missed-event vector drives the error interrupt. A dispatch port offers the lowest-numbered channel that is ready. When the transfer engine accepts that channel, the event moves into the in-service flag. Completion reports from the engine set interrupt pending bits. A completion interrupt pulse fires when the enabled pending set stops being empty. Two evaluate addresses let software request a fresh pulse while work is still outstanding.

Top module: `dma_chan_evbank`

## Requirements
- R1: Channel n lives in 32-bit word n>>5 at bit n&31. A register address is {register id[4:0], word select[0]}. Reads of set, clear and evaluate ids return zero. Writes to read-only ids (0 event, 3 enable, 6 in-service, 8 interrupt enable, 11 interrupt pending, 13 missed) have no effect.
- R2: A 1 written to event-set (id 1) sets that channel's event bit whatever its enable state. A 1 written to event-clear (id 2) clears it. The event vector reads at id 0.
- R3: A rising edge on evt_req[n] latches event bit n only while enable bit n is 1. The enable vector reads at id 3, is set through id 4 and is cleared through id 5. A request held high latches only once.
- R4: disp_valid is 1 whenever some channel has its event bit at 1 and its in-service bit at 0. disp_chan is then the lowest such channel.
- R5: disp_take together with disp_valid clears the event bit of disp_chan and sets its in-service bit on the next edge. The in-service vector reads at id 6 and is cleared through id 7.
- R6: A rising request edge on an enabled channel whose event or in-service bit is already 1 sets its missed bit and leaves the event bit unchanged. The missed vector reads at id 13 and is cleared through id 14.
- R7: irq_err is a one-cycle pulse in the cycle after the missed vector goes from all-zero to non-zero. Writing bit 0 = 1 to id 16 pulses irq_err in the next cycle if any missed bit is still set.
- R8: done_valid sets the interrupt pending bit of done_chan. The pending vector reads at id 11 and is cleared through id 12. Interrupt enables read at id 8, are set through id 9 and are cleared through id 10.
- R9: irq_done is a one-cycle pulse in the cycle after (pending AND enable) goes from all-zero to non-zero. Writing bit 0 = 1 to id 15 pulses irq_done in the next cycle if that product is non-zero.
- R10: A clear write to a bit wins over a set of the same bit from any source in the same cycle.
- R11: After reset every state vector is zero, and disp_valid, irq_done and irq_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {id, word} |
| wr_data | input | 32 | Write data, one bit per channel of the word |
| rd_addr | input | 6 | Read address {id, word} |
| rd_data | output | 32 | Combinational read data |
| evt_req | input | 64 | Hardware event request lines |
| disp_valid | output | 1 | A channel is ready to start |
| disp_chan | output | 6 | Lowest ready channel |
| disp_take | input | 1 | Engine accepts disp_chan |
| done_valid | input | 1 | Completion report strobe |
| done_chan | input | 6 | Channel whose interrupt pending bit is set |
| irq_done | output | 1 | Completion interrupt pulse |
| irq_err | output | 1 | Missed-event interrupt pulse |

## Verification
The bench aims at the word/bit split with a channel in the upper word. A design that mapped channels wrongly would show the bit in the wrong word. It raises a request on a disabled channel and holds one request high. A level-sensitive latch would set events the requirement forbids. It stacks a second request onto a pending channel and onto an in-service channel, where a wrong design would drop the miss or overwrite the event. It also drives a clear write and a hardware request into the same bit in one cycle, to catch set-over-clear priority. For interrupts, it checks that enabling a second pending channel gives no new pulse while one is already active, and that the evaluate writes pulse again only when work is left.

// File: rtl/evbank_pkg.sv
package evbank_pkg;

    localparam int N_CH    = 64;
    localparam int WORD_W  = 32;
    localparam int N_WORDS = N_CH / WORD_W;
    localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam int RID_W   = 5;
    localparam int ADDR_W  = RID_W + WSEL_W;
    localparam int CH_W    = $clog2(N_CH);

    typedef logic [N_CH-1:0] chvec_t;

    typedef enum logic [RID_W-1:0] {
        RID_EVT       = 5'd0,
        RID_EVT_SET   = 5'd1,
        RID_EVT_CLR   = 5'd2,
        RID_ENA       = 5'd3,
        RID_ENA_SET   = 5'd4,
        RID_ENA_CLR   = 5'd5,
        RID_SEC       = 5'd6,
        RID_SEC_CLR   = 5'd7,
        RID_IEN       = 5'd8,
        RID_IEN_SET   = 5'd9,
        RID_IEN_CLR   = 5'd10,
        RID_IPD       = 5'd11,
        RID_IPD_CLR   = 5'd12,
        RID_MISS      = 5'd13,
        RID_MISS_CLR  = 5'd14,
        RID_DONE_EVAL = 5'd15,
        RID_ERR_EVAL  = 5'd16
    } rid_e;

    typedef struct packed {
        chvec_t evt_set;
        chvec_t evt_clr;
        chvec_t ena_set;
        chvec_t ena_clr;
        chvec_t sec_clr;
        chvec_t ien_set;
        chvec_t ien_clr;
        chvec_t ipd_clr;
        chvec_t miss_clr;
        logic   eval_done;
        logic   eval_err;
    } wr_cmd_t;

    function automatic chvec_t ch_onehot(input logic [CH_W-1:0] ch);
        chvec_t v;
        v = '0;
        v[ch] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/evbank_wdec.sv
module evbank_wdec
    import evbank_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output wr_cmd_t           cmd
);
    logic [RID_W-1:0]  rid;
    logic [WSEL_W-1:0] wsel;
    chvec_t            dexp;

    assign rid  = wr_addr[ADDR_W-1:WSEL_W];
    assign wsel = wr_addr[WSEL_W-1:0];

    for (genvar w = 0; w < N_WORDS; w++) begin : g_word
        assign dexp[w*WORD_W +: WORD_W] = (wsel == WSEL_W'(w)) ? wr_data : '0;
    end

    always_comb begin
        cmd = '0;
        if (wr_en) begin
            unique case (rid)
                RID_EVT_SET:   cmd.evt_set   = dexp;
                RID_EVT_CLR:   cmd.evt_clr   = dexp;
                RID_ENA_SET:   cmd.ena_set   = dexp;
                RID_ENA_CLR:   cmd.ena_clr   = dexp;
                RID_SEC_CLR:   cmd.sec_clr   = dexp;
                RID_IEN_SET:   cmd.ien_set   = dexp;
                RID_IEN_CLR:   cmd.ien_clr   = dexp;
                RID_IPD_CLR:   cmd.ipd_clr   = dexp;
                RID_MISS_CLR:  cmd.miss_clr  = dexp;
                RID_DONE_EVAL: cmd.eval_done = wr_data[0];
                RID_ERR_EVAL:  cmd.eval_err  = wr_data[0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evbank_pick.sv
module evbank_pick #(
    parameter int WIDTH = 64,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/evbank_irq_pulse.sv
module evbank_irq_pulse (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic eval,
    output logic pulse
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            level_q <= level;
            pulse   <= (level & ~level_q) | (eval & level);
        end
    end
endmodule

// File: rtl/dma_chan_evbank.sv
module dma_chan_evbank
    import evbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [5:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [5:0]        rd_addr,
    output logic [31:0]       rd_data,
    input  logic [63:0]       evt_req,
    output logic              disp_valid,
    output logic [5:0]        disp_chan,
    input  logic              disp_take,
    input  logic              done_valid,
    input  logic [5:0]        done_chan,
    output logic              irq_done,
    output logic              irq_err
);
    wr_cmd_t cmd;
    chvec_t  evt, ena, sec, ien, ipd, miss;
    chvec_t  req_q, rise, hw_hit, hw_lat, hw_miss;
    chvec_t  take_m, done_m, ready;
    logic    act_any, miss_any;

    evbank_wdec u_wdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd     (cmd)
    );

    // Edge detection and classification of hardware requests
    assign rise    = evt_req & ~req_q;
    assign hw_hit  = rise & ena;
    assign hw_lat  = hw_hit & ~(evt | sec);
    assign hw_miss = hw_hit & (evt | sec);

    assign ready = evt & ~sec;

    evbank_pick #(.WIDTH(N_CH)) u_pick (
        .req   (ready),
        .valid (disp_valid),
        .idx   (disp_chan)
    );

    assign take_m = (disp_take && disp_valid) ? ch_onehot(disp_chan) : '0;
    assign done_m = done_valid ? ch_onehot(done_chan) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            evt   <= '0;
            ena   <= '0;
            sec   <= '0;
            ien   <= '0;
            ipd   <= '0;
            miss  <= '0;
        end else begin
            req_q <= evt_req;
            evt   <= (evt | cmd.evt_set | hw_lat) & ~cmd.evt_clr & ~take_m;
            ena   <= (ena | cmd.ena_set) & ~cmd.ena_clr;
            sec   <= (sec | take_m) & ~cmd.sec_clr;
            ien   <= (ien | cmd.ien_set) & ~cmd.ien_clr;
            ipd   <= (ipd | done_m) & ~cmd.ipd_clr;
            miss  <= (miss | hw_miss) & ~cmd.miss_clr;
        end
    end

    assign act_any  = |(ipd & ien);
    assign miss_any = |miss;

    evbank_irq_pulse u_done_irq (
        .clk   (clk),
        .rst   (rst),
        .level (act_any),
        .eval  (cmd.eval_done),
        .pulse (irq_done)
    );

    evbank_irq_pulse u_err_irq (
        .clk   (clk),
        .rst   (rst),
        .level (miss_any),
        .eval  (cmd.eval_err),
        .pulse (irq_err)
    );

    // Register read port
    logic [RID_W-1:0]  rd_rid;
    logic [WSEL_W-1:0] rd_wsel;
    chvec_t            rd_vec;

    assign rd_rid  = rd_addr[ADDR_W-1:WSEL_W];
    assign rd_wsel = rd_addr[WSEL_W-1:0];

    always_comb begin
        unique case (rd_rid)
            RID_EVT:  rd_vec = evt;
            RID_ENA:  rd_vec = ena;
            RID_SEC:  rd_vec = sec;
            RID_IEN:  rd_vec = ien;
            RID_IPD:  rd_vec = ipd;
            RID_MISS: rd_vec = miss;
            default:  rd_vec = '0;
        endcase
    end

    assign rd_data = rd_vec[rd_wsel*WORD_W +: WORD_W];

    // Assertions
    p_ready_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (evt[disp_chan] && !sec[disp_chan]));

    p_take_sets_sec_r5: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && disp_take && !(wr_en && wr_addr[5:1] == RID_SEC_CLR))
        |=> sec[$past(disp_chan)]);

    p_miss_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (|($past(miss) & ~miss)) |-> $past(wr_en && wr_addr[5:1] == RID_MISS_CLR));

    p_err_needs_miss_r7: assert property (@(posedge clk) disable iff (rst)
        irq_err |-> $past(miss_any));

    p_done_needs_pend_r9: assert property (@(posedge clk) disable iff (rst)
        irq_done |-> $past(act_any));

    p_ipd_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (|($past(ipd) & ~ipd)) |-> $past(wr_en && wr_addr[5:1] == RID_IPD_CLR));
endmodule

// File: tb/dma_chan_evbank_tb.sv
module dma_chan_evbank_tb;
    import evbank_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [31:0] wr_data;
    logic [5:0]  rd_addr;
    logic [31:0] rd_data;
    logic [63:0] evt_req;
    logic        disp_valid;
    logic [5:0]  disp_chan;
    logic        disp_take;
    logic        done_valid;
    logic [5:0]  done_chan;
    logic        irq_done;
    logic        irq_err;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_chan_evbank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_req(evt_req),
        .disp_valid(disp_valid), .disp_chan(disp_chan), .disp_take(disp_take),
        .done_valid(done_valid), .done_chan(done_chan),
        .irq_done(irq_done), .irq_err(irq_err)
    );

    always @(negedge clk) begin
        if (irq_done) done_cnt++;
        if (irq_err)  err_cnt++;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(rid_e rid, bit word, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {rid, word}; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(rid_e rid, bit word, output logic [31:0] data);
        rd_addr = {rid, word};
        #1;
        data = rd_data;
    endtask

    task automatic hw_pulse(int ch);
        @(negedge clk); evt_req[ch] = 1'b1;
        @(negedge clk); evt_req[ch] = 1'b0;
    endtask

    task automatic take();
        @(negedge clk); disp_take = 1'b1;
        @(negedge clk); disp_take = 1'b0;
    endtask

    task automatic report_done(int ch);
        @(negedge clk); done_valid = 1'b1; done_chan = 6'(ch);
        @(negedge clk); done_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int w = 0; w < 2; w++) begin
            reg_wr(RID_EVT_CLR, w[0], '1);
            reg_wr(RID_ENA_CLR, w[0], '1);
            reg_wr(RID_SEC_CLR, w[0], '1);
            reg_wr(RID_IEN_CLR, w[0], '1);
            reg_wr(RID_IPD_CLR, w[0], '1);
            reg_wr(RID_MISS_CLR, w[0], '1);
        end
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(RID_EVT, 1'b0, d);  chk("R11 evt0", d, 0);
        reg_rd(RID_MISS, 1'b1, d); chk("R11 miss1", d, 0);
        reg_rd(RID_ENA, 1'b1, d);  chk("R11 ena1", d, 0);
        chk("R11 disp_valid", 32'(disp_valid), 0);
        chk("R11 irqs", {30'b0, irq_done, irq_err}, 0);
    endtask

    task automatic t_soft_set();
        logic [31:0] d;
        reg_wr(RID_EVT_SET, 1'b1, 32'h1 << 5);      // channel 37
        reg_rd(RID_EVT, 1'b1, d); chk("R1 R2 evt word1 ch37", d, 32'h20);
        reg_rd(RID_EVT, 1'b0, d); chk("R1 evt word0 untouched", d, 0);
        chk("R4 disp ch37", {26'b0, disp_chan}, 37);
        reg_rd(RID_EVT_SET, 1'b1, d); chk("R1 set id reads zero", d, 0);
        reg_wr(RID_EVT_CLR, 1'b1, 32'h20);
        reg_rd(RID_EVT, 1'b1, d); chk("R2 evt clear", d, 0);
        reg_wr(RID_EVT, 1'b0, '1);                  // read-only id
        reg_rd(RID_EVT, 1'b0, d); chk("R1 ro write ignored", d, 0);
        clear_all();
    endtask

    task automatic t_hw_enable();
        logic [31:0] d;
        hw_pulse(3);
        reg_rd(RID_EVT, 1'b0, d); chk("R3 disabled no latch", d, 0);
        reg_wr(RID_ENA_SET, 1'b0, 32'h8);
        reg_rd(RID_ENA, 1'b0, d); chk("R3 ena set", d, 32'h8);
        hw_pulse(3);
        reg_rd(RID_EVT, 1'b0, d); chk("R3 enabled latch", d, 32'h8);
        reg_wr(RID_EVT_CLR, 1'b0, 32'h8);
        @(negedge clk); evt_req[3] = 1'b1;
        repeat (2) @(negedge clk);
        reg_wr(RID_EVT_CLR, 1'b0, 32'h8);
        repeat (3) @(negedge clk);
        reg_rd(RID_EVT, 1'b0, d); chk("R3 held level no relatch", d, 0);
        evt_req[3] = 1'b0;
        reg_wr(RID_ENA_CLR, 1'b0, 32'h8);
        reg_rd(RID_ENA, 1'b0, d); chk("R3 ena clear", d, 0);
        clear_all();
    endtask

    task automatic t_dispatch();
        logic [31:0] d;
        reg_wr(RID_EVT_SET, 1'b1, 32'h100);          // ch40
        reg_wr(RID_EVT_SET, 1'b0, 32'h400);          // ch10
        chk("R4 lowest first", {26'b0, disp_chan}, 10);
        take();
        reg_rd(RID_EVT, 1'b0, d); chk("R5 evt cleared", d, 0);
        reg_rd(RID_SEC, 1'b0, d); chk("R5 sec set", d, 32'h400);
        chk("R4 next ch40", {26'b0, disp_chan}, 40);
        take();
        chk("R4 none ready", 32'(disp_valid), 0);
        reg_wr(RID_EVT_SET, 1'b0, 32'h400);
        chk("R4 sec blocks", 32'(disp_valid), 0);
        reg_wr(RID_SEC_CLR, 1'b0, 32'h400);
        reg_rd(RID_SEC, 1'b0, d); chk("R5 sec clear", d, 0);
        chk("R4 ch10 ready again", {25'b0, disp_valid, disp_chan}, {25'b0, 1'b1, 6'd10});
        clear_all();
    endtask

    task automatic t_miss();
        logic [31:0] d;
        int e0;
        e0 = err_cnt;
        reg_wr(RID_ENA_SET, 1'b0, 32'h80);
        hw_pulse(7);
        hw_pulse(7);
        settle();
        reg_rd(RID_MISS, 1'b0, d); chk("R6 miss on pending", d, 32'h80);
        reg_rd(RID_EVT, 1'b0, d);  chk("R6 evt kept", d, 32'h80);
        chk("R7 err pulse", 32'(err_cnt - e0), 1);
        reg_wr(RID_ERR_EVAL, 1'b0, 32'h1);
        settle();
        chk("R7 eval re-pulse", 32'(err_cnt - e0), 2);
        reg_wr(RID_MISS_CLR, 1'b0, 32'h80);
        reg_rd(RID_MISS, 1'b0, d); chk("R6 miss clear", d, 0);
        reg_wr(RID_ERR_EVAL, 1'b0, 32'h1);
        settle();
        chk("R7 eval idle no pulse", 32'(err_cnt - e0), 2);
        take();
        hw_pulse(7);
        reg_rd(RID_MISS, 1'b0, d); chk("R6 miss on in-service", d, 32'h80);
        reg_rd(RID_EVT, 1'b0, d);  chk("R6 evt stays clear", d, 0);
        clear_all();
    endtask

    task automatic t_done_irq();
        logic [31:0] d;
        int c0;
        c0 = done_cnt;
        reg_wr(RID_IEN_SET, 1'b1, 32'h2);            // ch33
        reg_rd(RID_IEN, 1'b1, d); chk("R8 ien set", d, 32'h2);
        report_done(33);
        chk("R9 no pulse yet", 32'(irq_done), 0);
        @(negedge clk);
        chk("R9 pulse next cycle", 32'(irq_done), 1);
        @(negedge clk);
        chk("R9 one cycle", 32'(irq_done), 0);
        reg_rd(RID_IPD, 1'b1, d); chk("R8 ipd ch33", d, 32'h2);
        report_done(2);
        reg_wr(RID_IEN_SET, 1'b0, 32'h4);
        settle();
        chk("R9 no pulse while active", 32'(done_cnt - c0), 1);
        reg_wr(RID_DONE_EVAL, 1'b0, 32'h1);
        settle();
        chk("R9 eval pulse", 32'(done_cnt - c0), 2);
        reg_wr(RID_IPD_CLR, 1'b1, 32'h2);
        reg_wr(RID_IPD_CLR, 1'b0, 32'h4);
        reg_rd(RID_IPD, 1'b0, d); chk("R8 ipd clear", d, 0);
        reg_wr(RID_IEN_CLR, 1'b0, 32'h4);
        report_done(2);
        settle();
        chk("R9 disabled no pulse", 32'(done_cnt - c0), 2);
        reg_rd(RID_IPD, 1'b0, d); chk("R8 ipd set when disabled", d, 32'h4);
        clear_all();
    endtask

    task automatic t_clear_wins();
        logic [31:0] d;
        reg_wr(RID_ENA_SET, 1'b0, 32'h1000);        // ch12
        @(negedge clk);
        evt_req[12] = 1'b1;
        wr_en = 1'b1; wr_addr = {RID_EVT_CLR, 1'b0}; wr_data = 32'h1000;
        @(negedge clk);
        wr_en = 1'b0; evt_req[12] = 1'b0;
        reg_rd(RID_EVT, 1'b0, d);  chk("R10 clear beats hw set", d, 0);
        reg_rd(RID_MISS, 1'b0, d); chk("R10 no miss", d, 0);
        clear_all();
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        evt_req = '0; disp_take = 0; done_valid = 0; done_chan = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_soft_set();
        t_hw_enable();
        t_dispatch();
        t_miss();
        t_done_irq();
        t_clear_wins();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule